// File: doc/BRIEF.md
# Load Data Extension Formatter

This unit sits between the data-memory read port and the register-file write path of a 64-bit processing core. It accepts a load request made of a mode field, a size field, a 64-bit base register value and a signed 16-bit displacement. From these it forms the byte address, checks that the request is one it can serve, and issues a single read. When the 64-bit aligned read data comes back, it selects the addressed bytes and widens them to 64 bits, filling the upper bits either with zeros or with copies of the sign bit.

Only one request is in flight at a time. Requests with an unsupported mode or size combination raise `illegal`. Requests whose bytes would spill past an 8-byte line raise `misaligned`. Neither kind ever reaches memory. The memory model, stores and atomic operations belong to other units.

Top module: `load_ext_fmt`

## Requirements
- R1: The read address is `req_base` plus `req_offset` sign-extended to 64 bits. It appears on `mem_addr` in the cycle after the request is accepted, together with a one-cycle `mem_rd` pulse, and it holds steady while `busy` is high.
- R2: Mode value 3 (mode bits equal to 0x60 in an 8-bit opcode) is a zero-extending load. It accepts all four size codes: 0 = 4 bytes, 1 = 2 bytes, 2 = 1 byte, 3 = 8 bytes. Result bits above the loaded width are zero.
- R3: Mode value 4 (mode bits equal to 0x80) is a sign-extending load for size codes 0, 1 and 2. Result bits above the loaded width copy the loaded value's top bit.
- R4: Loaded bytes are taken little-endian from `mem_data`. The lowest-addressed byte comes from lane `mem_addr[2:0]`, where lane k is bits 8k+7..8k.
- R5: A sign-extending load with size code 3 raises `illegal` for one cycle, in the cycle after acceptance, and issues no read.
- R6: Every mode value other than 3 and 4 raises `illegal` for one cycle and issues no read. This covers 1 and 2 (packet access) and 6 (atomic).
- R7: A legal request whose lane plus byte count exceeds 8 raises `misaligned` for one cycle and issues no read. When a request is both illegal and misaligned, only `illegal` is raised.
- R8: `result_valid` pulses in the cycle after `mem_valid` is sampled while busy. `busy` is high from the `mem_rd` cycle until that cycle. A request presented while busy is ignored.
- R9: After reset, all outputs are zero.
- R10: A `mem_valid` pulse while not busy produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present (accepted when not busy) |
| req_mode | input | 3 | Mode field (3 zero-extend, 4 sign-extend) |
| req_size | input | 2 | Size code (0 word, 1 half, 2 byte, 3 double) |
| req_base | input | 64 | Base register value |
| req_offset | input | 16 | Signed displacement |
| mem_addr | output | 64 | Byte address of the read |
| mem_rd | output | 1 | One-cycle read request |
| mem_data | input | 64 | Aligned 64-bit read data |
| mem_valid | input | 1 | Read data valid strobe |
| busy | output | 1 | A read is outstanding |
| result | output | 64 | Extended load result |
| result_valid | output | 1 | Result strobe |
| illegal | output | 1 | Unsupported mode/size request |
| misaligned | output | 1 | Access would cross an 8-byte line |

## Verification
Each accepted request has one of three outcomes, and each is due exactly one cycle after the edge that causes it. `mem_rd` (or `illegal` or `misaligned`) is due one cycle after acceptance, and `result_valid` is due one cycle after the edge that samples `mem_valid`. The driver drives inputs on falling edges and pushes the expected outcome before it presents the request. The monitor samples shortly after every falling edge, so each registered output is compared in the cycle it is due. Any flag that appears with nothing expected counts as a mismatch.

// File: rtl/load_ext_pkg.sv
package load_ext_pkg;

    localparam int XLEN     = 64;
    localparam int LANES    = XLEN / 8;
    localparam int LANE_W   = $clog2(LANES);

    typedef enum logic [2:0] {
        MODE_IMM   = 3'd0,
        MODE_PABS  = 3'd1,
        MODE_PIND  = 3'd2,
        MODE_ZX    = 3'd3,
        MODE_SX    = 3'd4,
        MODE_RSV5  = 3'd5,
        MODE_ATOM  = 3'd6,
        MODE_RSV7  = 3'd7
    } ld_mode_e;

    typedef enum logic [1:0] {
        SZ_WORD  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_BYTE  = 2'd2,
        SZ_DWORD = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        CHK_OK       = 2'd0,
        CHK_ILLEGAL  = 2'd1,
        CHK_MISALIGN = 2'd2
    } ld_chk_e;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        ld_size_e          size;
        logic              sext;
    } ld_info_t;

    function automatic int unsigned size_bytes(ld_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int unsigned size_index(ld_size_e s);
        case (s)
            SZ_BYTE: return 0;
            SZ_HALF: return 1;
            SZ_WORD: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic mode_legal(ld_mode_e m, ld_size_e s);
        return (m == MODE_ZX) || ((m == MODE_SX) && (s != SZ_DWORD));
    endfunction

endpackage

// File: rtl/load_ext_agen.sv
module load_ext_agen
    import load_ext_pkg::*;
#(
    parameter int ADDR_W = XLEN,
    parameter int OFFS_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    input  ld_mode_e          mode,
    input  ld_size_e          size,
    output logic [ADDR_W-1:0] addr,
    output ld_info_t          info,
    output ld_chk_e           chk
);
    localparam int EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] disp;
    logic              span_bad;

    assign disp = {{EXT_W{offset[OFFS_W-1]}}, offset};
    assign addr = base + disp;

    assign info.lane = addr[LANE_W-1:0];
    assign info.size = size;
    assign info.sext = (mode == MODE_SX);

    always_comb begin
        span_bad = (int'(addr[LANE_W-1:0]) + int'(size_bytes(size))) > LANES;
        if (!mode_legal(mode, size)) begin
            chk = CHK_ILLEGAL;
        end else if (span_bad) begin
            chk = CHK_MISALIGN;
        end else begin
            chk = CHK_OK;
        end
    end
endmodule

// File: rtl/load_ext_ctrl.sv
module load_ext_ctrl
    import load_ext_pkg::*;
#(
    parameter int ADDR_W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  ld_chk_e           chk,
    input  logic [ADDR_W-1:0] addr_in,
    input  ld_info_t          info_in,
    input  logic              rsp_valid,
    output logic [ADDR_W-1:0] addr_q,
    output ld_info_t          info_q,
    output logic              rd_q,
    output logic              busy_q,
    output logic              ill_q,
    output logic              mis_q,
    output logic              capture
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            info_q <= '0;
            rd_q   <= 1'b0;
            busy_q <= 1'b0;
            ill_q  <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            rd_q  <= 1'b0;
            ill_q <= 1'b0;
            mis_q <= 1'b0;
            if (!busy_q) begin
                if (req_valid) begin
                    case (chk)
                        CHK_OK: begin
                            busy_q <= 1'b1;
                            rd_q   <= 1'b1;
                            addr_q <= addr_in;
                            info_q <= info_in;
                        end
                        CHK_ILLEGAL: ill_q <= 1'b1;
                        default:     mis_q <= 1'b1;
                    endcase
                end
            end else if (rsp_valid) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign capture = busy_q && rsp_valid;
endmodule

// File: rtl/load_ext_lane.sv
module load_ext_lane
    import load_ext_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic [DATA_W-1:0] line,
    input  ld_info_t          info,
    output logic [DATA_W-1:0] value
);
    localparam int NSIZES = 4;

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] cand [NSIZES];

    assign shifted = line >> {info.lane, 3'b000};

    for (genvar k = 0; k < NSIZES; k++) begin : g_width
        localparam int W = 8 << k;
        if (W < DATA_W) begin : g_ext
            assign cand[k] = {{(DATA_W-W){info.sext & shifted[W-1]}}, shifted[W-1:0]};
        end else begin : g_full
            assign cand[k] = shifted;
        end
    end

    always_comb begin
        value = cand[size_index(info.size)];
    end
endmodule

// File: rtl/load_ext_fmt.sv
module load_ext_fmt
    import load_ext_pkg::*;
#(
    parameter int ADDR_W = XLEN,
    parameter int OFFS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFFS_W-1:0] req_offset,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [XLEN-1:0]   mem_data,
    input  logic              mem_valid,
    output logic              busy,
    output logic [XLEN-1:0]   result,
    output logic              result_valid,
    output logic              illegal,
    output logic              misaligned
);
    logic [ADDR_W-1:0] ag_addr;
    ld_info_t          ag_info;
    ld_chk_e           ag_chk;
    ld_info_t          held_info;
    logic              capture;
    logic [XLEN-1:0]   ext_value;
    logic [XLEN-1:0]   result_q;
    logic              result_valid_q;

    load_ext_agen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_agen (
        .base   (req_base),
        .offset (req_offset),
        .mode   (ld_mode_e'(req_mode)),
        .size   (ld_size_e'(req_size)),
        .addr   (ag_addr),
        .info   (ag_info),
        .chk    (ag_chk)
    );

    load_ext_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .chk       (ag_chk),
        .addr_in   (ag_addr),
        .info_in   (ag_info),
        .rsp_valid (mem_valid),
        .addr_q    (mem_addr),
        .info_q    (held_info),
        .rd_q      (mem_rd),
        .busy_q    (busy),
        .ill_q     (illegal),
        .mis_q     (misaligned),
        .capture   (capture)
    );

    load_ext_lane #(.DATA_W(XLEN)) u_lane (
        .line  (mem_data),
        .info  (held_info),
        .value (ext_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q       <= '0;
            result_valid_q <= 1'b0;
        end else begin
            result_valid_q <= capture;
            if (capture) begin
                result_q <= ext_value;
            end
        end
    end

    assign result       = result_q;
    assign result_valid = result_valid_q;
endmodule

// File: rtl/load_ext_fmt_chk.sv
module load_ext_fmt_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_valid,
    input logic              busy,
    input logic              result_valid,
    input logic              illegal,
    input logic              misaligned
);
    // R5 R6 R7
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, illegal, misaligned, result_valid}));

    // R8
    rd_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    // R8
    single_issue_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R8
    resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ($past(mem_valid) && $past(busy)));

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd) |-> $stable(mem_addr));

    // R10
    stray_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && mem_valid) |=> !result_valid);

    // R5
    illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy);
endmodule

bind load_ext_fmt load_ext_fmt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_rd       (mem_rd),
    .mem_valid    (mem_valid),
    .busy         (busy),
    .result_valid (result_valid),
    .illegal      (illegal),
    .misaligned   (misaligned)
);

// File: tb/load_ext_fmt_test.sv
module load_ext_fmt_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [63:0] mem_addr;
    logic        mem_rd;
    logic [63:0] mem_data = '0;
    logic        mem_valid = 1'b0;
    logic        busy;
    logic [63:0] result;
    logic        result_valid;
    logic        illegal;
    logic        misaligned;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        int          kind;
        logic [63:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    localparam int K_RES = 0;
    localparam int K_ILL = 1;
    localparam int K_MIS = 2;

    always #10 clk = ~clk;

    load_ext_fmt uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
        .mem_valid(mem_valid), .busy(busy), .result(result),
        .result_valid(result_valid), .illegal(illegal), .misaligned(misaligned)
    );

    function automatic logic [7:0] mem_byte(logic [63:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'h47;
    endfunction

    function automatic logic [63:0] mem_line(logic [63:0] a);
        logic [63:0] l;
        logic [63:0] b;
        b = {a[63:3], 3'b000};
        for (int i = 0; i < 8; i++) l[i*8 +: 8] = mem_byte(b + 64'(i));
        return l;
    endfunction

    function automatic int nbytes(logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 2;
            2'd2: return 1;
            default: return 8;
        endcase
    endfunction

    function automatic logic [63:0] expect_val(logic [63:0] a, int n, logic sx);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < n; i++) v[i*8 +: 8] = mem_byte(a + 64'(i));
        if (sx && v[n*8-1]) begin
            for (int j = n*8; j < 64; j++) v[j] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever an outcome strobe appears.
    always @(negedge clk) begin
        #2;
        if (!rst && (result_valid || illegal || misaligned)) begin
            int k;
            k = result_valid ? K_RES : (illegal ? K_ILL : K_MIS);
            if (exp_q.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R8: unexpected outcome kind actual %0d expected none", k);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " kind"}, 64'(k), 64'(e.kind));
                if (e.kind == K_RES) check({e.tag, " value"}, result, e.val);
            end
        end
    end

    // Driver: called at a falling edge, returns at a falling edge.
    task automatic do_load(logic [2:0] m, logic [1:0] s, logic [63:0] base,
                           logic [15:0] off, int lat, string tag);
        logic [63:0] a;
        int n;
        logic legal;
        logic span;
        exp_t e;
        a = base + {{48{off[15]}}, off};
        n = nbytes(s);
        legal = (m == 3'd3) || (m == 3'd4 && s != 2'd3);
        span = (int'(a[2:0]) + n) > 8;
        e.tag = tag;
        e.val = '0;
        if (!legal) e.kind = K_ILL;
        else if (span) e.kind = K_MIS;
        else begin
            e.kind = K_RES;
            e.val = expect_val(a, n, m == 3'd4);
        end
        exp_q.push_back(e);
        req_valid = 1'b1; req_mode = m; req_size = s; req_base = base; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        if (e.kind != K_RES) begin
            check({tag, " no read"}, 64'(mem_rd), 64'd0);
            check({tag, " not busy"}, 64'(busy), 64'd0);
        end else begin
            check({tag, " R1 read strobe"}, 64'(mem_rd), 64'd1);
            check({tag, " R1 address"}, mem_addr, a);
            check({tag, " R8 busy"}, 64'(busy), 64'd1);
            repeat (lat) @(negedge clk);
            check({tag, " R1 address held"}, mem_addr, a);
            mem_valid = 1'b1;
            mem_data = mem_line(a);
            @(negedge clk);
            mem_valid = 1'b0;
            mem_data = '0;
            check({tag, " R8 busy released"}, 64'(busy), 64'd0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R8: watchdog expired actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 busy", 64'(busy), 64'd0);
        check("R9 mem_rd", 64'(mem_rd), 64'd0);
        check("R9 mem_addr", mem_addr, 64'd0);
        check("R9 result", result, 64'd0);
        check("R9 flags", {61'd0, result_valid, illegal, misaligned}, 64'd0);
        @(negedge clk);

        // R2 R4 zero-extending loads at every aligned lane
        for (int l = 0; l < 8; l++) do_load(3'd3, 2'd2, 64'h1000, 16'(l), 0, "R2 R4 zx byte");
        for (int l = 0; l < 8; l += 2) do_load(3'd3, 2'd1, 64'h2206, 16'(l - 6), 1, "R2 R4 zx half");
        for (int l = 0; l < 8; l += 4) do_load(3'd3, 2'd0, 64'h3380, 16'(l), 2, "R2 R4 zx word");
        do_load(3'd3, 2'd3, 64'h4488, 16'h0000, 3, "R2 zx dword");

        // R3 R4 sign-extending loads
        for (int l = 0; l < 8; l++) do_load(3'd4, 2'd2, 64'h1000, 16'(l), 0, "R3 R4 sx byte");
        for (int l = 0; l < 8; l += 2) do_load(3'd4, 2'd1, 64'h2200, 16'(l), 0, "R3 R4 sx half");
        for (int l = 0; l < 8; l += 4) do_load(3'd4, 2'd0, 64'h3380, 16'(l), 1, "R3 R4 sx word");
        for (int l = 0; l < 8; l += 4) do_load(3'd4, 2'd0, 64'h5A48, 16'(l), 0, "R3 sx word b");

        // R1 negative displacement
        do_load(3'd3, 2'd2, 64'h0000_0000_0001_0003, 16'h8000, 0, "R1 negative offset");
        do_load(3'd4, 2'd1, 64'hFFFF_FFFF_FFFF_FFF8, 16'h000A, 0, "R1 address wrap");

        // R5 sign-extend doubleword
        do_load(3'd4, 2'd3, 64'h1000, 16'h0000, 0, "R5 sx dword");
        // R6 other modes
        for (int m = 0; m < 8; m++) begin
            if (m != 3 && m != 4) do_load(3'(m), 2'd0, 64'h1000, 16'h0000, 0, "R6 bad mode");
        end
        // R7 spans and precedence
        do_load(3'd3, 2'd0, 64'h1005, 16'h0000, 0, "R7 word lane5");
        do_load(3'd3, 2'd1, 64'h1007, 16'h0000, 0, "R7 half lane7");
        do_load(3'd3, 2'd3, 64'h1001, 16'h0000, 0, "R7 dword lane1");
        do_load(3'd4, 2'd1, 64'h1000, 16'h0007, 0, "R7 sx half lane7");
        do_load(3'd6, 2'd3, 64'h1003, 16'h0000, 0, "R7 illegal wins");
        do_load(3'd4, 2'd3, 64'h1003, 16'h0000, 0, "R7 R5 illegal wins");

        // R8 request while busy is ignored
        begin
            exp_t e;
            e.kind = K_RES;
            e.val = expect_val(64'h6010, 2, 1'b0);
            e.tag = "R8 busy ignore";
            exp_q.push_back(e);
            req_valid = 1'b1; req_mode = 3'd3; req_size = 2'd1;
            req_base = 64'h6010; req_offset = 16'h0000;
            @(negedge clk);
            req_mode = 3'd4; req_size = 2'd2; req_base = 64'h7777; req_offset = 16'h0001;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 no second read", 64'(mem_rd), 64'd0);
            check("R8 address kept", mem_addr, 64'h6010);
            check("R8 still busy", 64'(busy), 64'd1);
            mem_valid = 1'b1;
            mem_data = mem_line(64'h6010);
            @(negedge clk);
            mem_valid = 1'b0;
            mem_data = '0;
            @(negedge clk);
            check("R8 idle after", 64'(busy), 64'd0);
        end

        // R10 stray response while idle
        mem_valid = 1'b1;
        mem_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        mem_valid = 1'b0;
        mem_data = '0;
        @(negedge clk);
        check("R10 no result", 64'(result_valid), 64'd0);
        check("R10 not busy", 64'(busy), 64'd0);

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule